// File: doc/BRIEF.md
# Asynchronous Serial Controller Register Interface

This block is the processor-facing front of an asynchronous serial controller. It watches an active-low chip select, active-low read and write strobes and a control/data select line, and steers every access to one of five places: the transmit holding register, the receive data register, the mode register, the command register or the status byte. The serial shift engines sit outside it and talk to it over plain internal signals. The transmit side offers a held character and the engine takes it. The receive side delivers a character with its parity and framing flags.

One control address serves two registers. After reset, the first control write is taken as the mode word. Every control write after that is a command, until a command with its internal-reset bit set makes the next control write a mode word again. Command bits drive the modem handshake outputs, the enables and the break and hunt controls. The status byte gathers the transmitter, receiver and error flags with the break-detect and data-set-ready inputs.

Top module: `sio_regif`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `dtr_n` and `rts_n` are 1. `mode_ok`, `tx_en`, `rx_en`, `brk_send`, `hunt` and `tx_avail` are 0. No character is held in either direction, and all three error flags are clear.
- R2: No access occurs unless `cs_n` is low. A write needs `wr_n` low. A read needs `rd_n` low and `wr_n` high. One access happens per strobe assertion, on the first clock edge that sees it, however long the strobe stays low.
- R3: While `mode_ok` is 0, a control write (`cd`=1) loads `din` into `mode_o` and sets `mode_ok` one cycle later. It changes no command output.
- R4: While `mode_ok` is 1, a control write with bit 6 clear is a command. One cycle later the outputs take these values: `tx_en`=bit 0, `dtr_n`=NOT bit 1, `rx_en`=bit 2, `brk_send`=bit 3, `rts_n`=NOT bit 5, `hunt`=bit 7.
- R5: A command with bit 6 set clears `mode_ok` one cycle later. Its other bits are ignored, and every other output keeps its value.
- R6: A data write (`cd`=0) loads the transmit holding register and marks it full. `tx_avail` equals full AND `tx_en`. A `tx_take` pulse empties the register unless a write arrives in the same cycle. A data write is ignored while `mode_ok` is 0.
- R7: A status read (`cd`=1) returns this byte. Bit 0 is transmitter ready (holding register empty). Bit 1 is receiver ready. Bit 2 is transmitter empty (holding register empty and `tx_busy` low). Bits 3, 4 and 5 are the parity, overrun and framing error flags. Bit 6 is `brk_det`. Bit 7 is NOT `dsr_n`.
- R8: A `rx_strobe` pulse with `rx_en` high stores `rx_char` and sets receiver ready. With `rx_en` low the pulse is ignored.
- R9: A data read returns the stored character, zero-extended, and clears receiver ready one cycle later, unless a new character is stored in that same cycle.
- R10: A character stored while receiver ready is set, and not being read in the same cycle, sets the overrun flag. `rx_perr` and `rx_ferr` on a stored character set the parity and framing flags. All three flags are sticky.
- R11: A command with bit 4 set and bit 6 clear clears all three error flags, unless a new error is flagged in the same cycle.
- R12: `dout` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dsr_n | input | 1 | Data set ready, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| mode_o | output | 8 | Stored mode word, for the engines |
| mode_ok | output | 1 | Mode word has been stored |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| brk_send | output | 1 | Force the line to space |
| hunt | output | 1 | Enter hunt command bit |
| tx_data | output | DATA_W | Held transmit character |
| tx_avail | output | 1 | Held character offered to the engine |
| tx_take | input | 1 | Engine has taken the held character |
| tx_busy | input | 1 | Engine is shifting a character |
| rx_char | input | DATA_W | Received character from the engine |
| rx_strobe | input | 1 | Received character is valid |
| rx_perr | input | 1 | Parity error on the received character |
| rx_ferr | input | 1 | Framing error on the received character |
| brk_det | input | 1 | Break condition seen on the line |

## Verification
Every register effect of an access appears on the first clock edge that samples the asserted strobe. The bench drives inputs at the falling edge and compares 8 ns after the rising edge. By then that edge's update is visible, and the strobe it captured is still applied. Read data is combinational from the current select and the stored state, so it is compared in the same window. A reference model updated at each rising edge yields the expected outputs, and one check is made per output per cycle. A read that starts while the receiver is ready returns the character in that window and shows receiver ready cleared on the next one.

// File: rtl/sio_regif_pkg.sv
package sio_regif_pkg;

   localparam int unsigned BUS_W = 8;

   // command word, most significant bit first; engines and software decode
   // these positions, so they are fixed
   typedef struct packed {
      logic hunt;     // bit 7
      logic ireset;   // bit 6
      logic rts;      // bit 5
      logic err_clr;  // bit 4
      logic brk;      // bit 3
      logic rxe;      // bit 2
      logic dtr;      // bit 1
      logic txe;      // bit 0
   } cmd_t;

   localparam int unsigned ST_TXRDY   = 0;
   localparam int unsigned ST_RXRDY   = 1;
   localparam int unsigned ST_TXEMPTY = 2;
   localparam int unsigned ST_PERR    = 3;
   localparam int unsigned ST_OERR    = 4;
   localparam int unsigned ST_FERR    = 5;
   localparam int unsigned ST_BRK     = 6;
   localparam int unsigned ST_DSR     = 7;

endpackage

// File: rtl/sio_strobe_dec.sv
module sio_strobe_dec #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic cd,
   output logic wr_ctl,
   output logic wr_dat,
   output logic rd_ctl,
   output logic rd_dat,
   output logic rd_act
);

   logic wr_lvl;
   logic rd_lvl;
   logic wr_p;
   logic rd_p;

   assign wr_lvl = ~cs_n & ~wr_n;
   assign rd_lvl = ~cs_n & ~rd_n & wr_n;

   generate
      if (EDGE_MODE) begin : g_edge
         logic wr_q;
         logic rd_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               wr_q <= 1'b0;
               rd_q <= 1'b0;
            end else begin
               wr_q <= wr_lvl;
               rd_q <= rd_lvl;
            end
         end
         assign wr_p = wr_lvl & ~wr_q;
         assign rd_p = rd_lvl & ~rd_q;
      end else begin : g_level
         assign wr_p = wr_lvl;
         assign rd_p = rd_lvl;
      end
   endgenerate

   assign wr_ctl = wr_p & cd;
   assign wr_dat = wr_p & ~cd;
   assign rd_ctl = rd_p & cd;
   assign rd_dat = rd_p & ~cd;
   assign rd_act = rd_lvl;

endmodule

// File: rtl/sio_ctrl_seq.sv
module sio_ctrl_seq
   import sio_regif_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_ctl,
   input  logic [BUS_W-1:0] din,
   output logic [BUS_W-1:0] mode_o,
   output logic             mode_ok,
   output cmd_t             cmd_o,
   output logic             err_clr
);

   cmd_t wcmd;
   logic is_cmd;

   assign wcmd   = cmd_t'(din);
   assign is_cmd = wr_ctl & mode_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_o  <= '0;
         mode_ok <= 1'b0;
         cmd_o   <= '0;
      end else if (wr_ctl) begin
         if (!mode_ok) begin
            mode_o  <= din;
            mode_ok <= 1'b1;
         end else if (wcmd.ireset) begin
            mode_ok <= 1'b0;
         end else begin
            cmd_o <= wcmd;
         end
      end
   end

   assign err_clr = is_cmd & wcmd.err_clr & ~wcmd.ireset;

endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   input  logic              busy,
   input  logic              enable,
   output logic [DATA_W-1:0] data_o,
   output logic              avail_o,
   output logic              txrdy,
   output logic              txempty
);

   logic full;

   always_ff @(posedge clk) begin
      if (rst) begin
         full   <= 1'b0;
         data_o <= '0;
      end else if (wr) begin
         full   <= 1'b1;
         data_o <= wdata;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   assign avail_o = full & enable;
   assign txrdy   = ~full;
   assign txempty = ~full & ~busy;

endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              strobe,
   input  logic [DATA_W-1:0] char_i,
   input  logic              perr_i,
   input  logic              ferr_i,
   input  logic              rd,
   input  logic              err_clr,
   output logic [DATA_W-1:0] data_o,
   output logic              rdy,
   output logic              pe,
   output logic              oe,
   output logic              fe
);

   logic take;
   logic ovr;

   assign take = strobe & enable;
   assign ovr  = take & rdy & ~rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_o <= '0;
         rdy    <= 1'b0;
      end else if (take) begin
         data_o <= char_i;
         rdy    <= 1'b1;
      end else if (rd) begin
         rdy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pe <= 1'b0;
         oe <= 1'b0;
         fe <= 1'b0;
      end else begin
         if (take && perr_i) pe <= 1'b1;
         else if (err_clr)   pe <= 1'b0;
         if (ovr)            oe <= 1'b1;
         else if (err_clr)   oe <= 1'b0;
         if (take && ferr_i) fe <= 1'b1;
         else if (err_clr)   fe <= 1'b0;
      end
   end

endmodule

// File: rtl/sio_regif.sv
module sio_regif
   import sio_regif_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          EDGE_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              cd,
   input  logic [BUS_W-1:0]  din,
   output logic [BUS_W-1:0]  dout,
   input  logic              dsr_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic [BUS_W-1:0]  mode_o,
   output logic              mode_ok,
   output logic              tx_en,
   output logic              rx_en,
   output logic              brk_send,
   output logic              hunt,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_avail,
   input  logic              tx_take,
   input  logic              tx_busy,
   input  logic [DATA_W-1:0] rx_char,
   input  logic              rx_strobe,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              brk_det
);

   localparam int unsigned PAD_W = BUS_W - DATA_W;

   generate
      if (DATA_W < 5 || DATA_W > BUS_W) begin : g_bad_width
         $error("sio_regif: DATA_W must lie between 5 and 8");
      end
   endgenerate

   logic wr_ctl, wr_dat, rd_ctl, rd_dat, rd_act;
   cmd_t cmd;
   logic err_clr;
   logic txrdy, txempty;
   logic [DATA_W-1:0] rx_data;
   logic rx_rdy, pe, oe, fe;
   logic [BUS_W-1:0] status;
   logic [BUS_W-1:0] rx_word;

   sio_strobe_dec #(.EDGE_MODE(EDGE_MODE)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .cs_n   (cs_n),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .cd     (cd),
      .wr_ctl (wr_ctl),
      .wr_dat (wr_dat),
      .rd_ctl (rd_ctl),
      .rd_dat (rd_dat),
      .rd_act (rd_act)
   );

   sio_ctrl_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .wr_ctl  (wr_ctl),
      .din     (din),
      .mode_o  (mode_o),
      .mode_ok (mode_ok),
      .cmd_o   (cmd),
      .err_clr (err_clr)
   );

   sio_tx_hold #(.DATA_W(DATA_W)) u_tx (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_dat & mode_ok),
      .wdata   (din[DATA_W-1:0]),
      .take    (tx_take),
      .busy    (tx_busy),
      .enable  (cmd.txe),
      .data_o  (tx_data),
      .avail_o (tx_avail),
      .txrdy   (txrdy),
      .txempty (txempty)
   );

   sio_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .enable  (cmd.rxe),
      .strobe  (rx_strobe),
      .char_i  (rx_char),
      .perr_i  (rx_perr),
      .ferr_i  (rx_ferr),
      .rd      (rd_dat),
      .err_clr (err_clr),
      .data_o  (rx_data),
      .rdy     (rx_rdy),
      .pe      (pe),
      .oe      (oe),
      .fe      (fe)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rx_word = {{PAD_W{1'b0}}, rx_data};
      end else begin : g_nopad
         assign rx_word = rx_data;
      end
   endgenerate

   always_comb begin
      status              = '0;
      status[ST_TXRDY]    = txrdy;
      status[ST_RXRDY]    = rx_rdy;
      status[ST_TXEMPTY]  = txempty;
      status[ST_PERR]     = pe;
      status[ST_OERR]     = oe;
      status[ST_FERR]     = fe;
      status[ST_BRK]      = brk_det;
      status[ST_DSR]      = ~dsr_n;
   end

   assign dout     = rd_act ? (cd ? status : rx_word) : '0;
   assign dtr_n    = ~cmd.dtr;
   assign rts_n    = ~cmd.rts;
   assign tx_en    = cmd.txe;
   assign rx_en    = cmd.rxe;
   assign brk_send = cmd.brk;
   assign hunt     = cmd.hunt;

endmodule

// File: rtl/sio_regif_chk.sv
module sio_regif_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic       clk,
   input logic       rst,
   input logic       cs_n,
   input logic       rd_n,
   input logic       wr_n,
   input logic [7:0] din,
   input logic [7:0] dout,
   input logic       dtr_n,
   input logic       rts_n,
   input logic [7:0] mode_o,
   input logic       mode_ok,
   input logic       tx_en,
   input logic       rx_en,
   input logic       rx_strobe,
   input logic       wr_ctl,
   input logic       rd_dat,
   input logic [7:0] status
);

   AST_CS_IGNORED: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> ($stable(mode_ok) && $stable(dtr_n) && $stable(rts_n) && $stable(mode_o))); // R2

   AST_MODE_FIRST: assert property (@(posedge clk) disable iff (rst)
      (wr_ctl && !mode_ok) |=> (mode_ok && mode_o == $past(din) && $stable(dtr_n) && $stable(tx_en))); // R3

   AST_CMD_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
      (wr_ctl && mode_ok && !din[6]) |=> (dtr_n == !$past(din[1]) && rts_n == !$past(din[5]))); // R4

   AST_IRESET_KEEP: assert property (@(posedge clk) disable iff (rst)
      (wr_ctl && mode_ok && din[6]) |=> (!mode_ok && $stable(dtr_n) && $stable(rts_n) && $stable(rx_en))); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (rd_dat && !(rx_strobe && rx_en)) |=> !status[1]); // R9

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
      (rx_strobe && rx_en && status[1] && !rd_dat) |=> status[4]); // R10

   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
      (wr_ctl && mode_ok && din[4] && !din[6] && !rx_strobe) |=> (status[5:3] == 3'b000)); // R11

   AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (cs_n || rd_n || !wr_n) |-> (dout == 8'h00)); // R12

endmodule

bind sio_regif sio_regif_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cs_n      (cs_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .din       (din),
   .dout      (dout),
   .dtr_n     (dtr_n),
   .rts_n     (rts_n),
   .mode_o    (mode_o),
   .mode_ok   (mode_ok),
   .tx_en     (tx_en),
   .rx_en     (rx_en),
   .rx_strobe (rx_strobe),
   .wr_ctl    (wr_ctl),
   .rd_dat    (rd_dat),
   .status    (status)
);

// File: tb/sio_regif_test.sv
module sio_regif_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       dsr_n = 1'b1;
   logic       dtr_n, rts_n;
   logic [7:0] mode_o;
   logic       mode_ok, tx_en, rx_en, brk_send, hunt;
   logic [7:0] tx_data;
   logic       tx_avail;
   logic       tx_take = 1'b0, tx_busy = 1'b0;
   logic [7:0] rx_char = 8'h00;
   logic       rx_strobe = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, brk_det = 1'b0;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sio_regif uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
      .din(din), .dout(dout), .dsr_n(dsr_n), .dtr_n(dtr_n), .rts_n(rts_n),
      .mode_o(mode_o), .mode_ok(mode_ok), .tx_en(tx_en), .rx_en(rx_en),
      .brk_send(brk_send), .hunt(hunt), .tx_data(tx_data), .tx_avail(tx_avail),
      .tx_take(tx_take), .tx_busy(tx_busy), .rx_char(rx_char), .rx_strobe(rx_strobe),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .brk_det(brk_det)
   );

   // ---------------- behavioural reference model ----------------
   bit       m_mode_exp = 1;
   int       m_mode = 0;
   int       m_cmd = 0;
   bit       m_full = 0;
   int       m_txd = 0;
   int       m_rxd = 0;
   bit       m_rdy = 0, m_pe = 0, m_oe = 0, m_fe = 0;
   bit       prev_w = 0, prev_r = 0;

   always @(posedge clk) begin
      bit w_now, r_now, w_acc, r_acc, rx_take, clr;
      w_now = !cs_n && !wr_n;
      r_now = !cs_n && !rd_n && wr_n;
      w_acc = w_now && !prev_w;
      r_acc = r_now && !prev_r;
      if (rst) begin
         m_mode_exp = 1; m_mode = 0; m_cmd = 0; m_full = 0; m_txd = 0;
         m_rxd = 0; m_rdy = 0; m_pe = 0; m_oe = 0; m_fe = 0;
         prev_w = 0; prev_r = 0;
      end else begin
         clr = 0;
         rx_take = rx_strobe && m_cmd[2];
         if (w_acc && cd) begin
            if (m_mode_exp) begin
               m_mode = din; m_mode_exp = 0;
            end else if (din[6]) begin
               m_mode_exp = 1;
            end else begin
               m_cmd = din;
               clr = din[4];
            end
         end
         if (w_acc && !cd && !m_mode_exp_before(w_acc)) begin
            m_full = 1; m_txd = din;
         end else if (tx_take) begin
            m_full = 0;
         end
         if (rx_take && m_rdy && !(r_acc && !cd)) m_oe = 1;
         else if (clr) m_oe = 0;
         if (rx_take && rx_perr) m_pe = 1;
         else if (clr) m_pe = 0;
         if (rx_take && rx_ferr) m_fe = 1;
         else if (clr) m_fe = 0;
         if (rx_take) begin
            m_rdy = 1; m_rxd = rx_char;
         end else if (r_acc && !cd) begin
            m_rdy = 0;
         end
         prev_w = w_now; prev_r = r_now;
         exp_before_cache = m_mode_exp;
      end
   end

   // mode state seen before this edge's control write took effect
   bit exp_before_cache = 1;
   bit m_mode_exp_prev = 1;
   always @(negedge clk) m_mode_exp_prev = m_mode_exp;
   function automatic bit m_mode_exp_before(bit unused);
      return m_mode_exp_prev;
   endfunction

   function automatic logic [7:0] exp_status();
      logic [7:0] s;
      s[0] = !m_full;
      s[1] = m_rdy;
      s[2] = !m_full && !tx_busy;
      s[3] = m_pe;
      s[4] = m_oe;
      s[5] = m_fe;
      s[6] = brk_det;
      s[7] = !dsr_n;
      return s;
   endfunction

   task automatic check(input string req, input string what, input int act, input int expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
      end
   endtask

   // per-cycle comparison, 8 ns after the rising edge
   always @(posedge clk) begin
      #8;
      if (!finished) begin
         logic [7:0] ed;
         bit reading;
         reading = !cs_n && !rd_n && wr_n;
         ed = !reading ? 8'h00 : (cd ? exp_status() : 8'(m_rxd));
         check(rst ? "R1" : "R4", "dtr_n", dtr_n, !m_cmd[1]);
         check(rst ? "R1" : "R4", "rts_n", rts_n, !m_cmd[5]);
         check("R4", "tx_en", tx_en, m_cmd[0]);
         check("R4", "rx_en", rx_en, m_cmd[2]);
         check("R4", "brk_send", brk_send, m_cmd[3]);
         check("R4", "hunt", hunt, m_cmd[7]);
         check(rst ? "R1" : "R3", "mode_ok", mode_ok, !m_mode_exp);
         check("R3", "mode_o", mode_o, m_mode);
         check("R6", "tx_avail", tx_avail, m_full && m_cmd[0]);
         if (m_full) check("R6", "tx_data", tx_data, m_txd);
         check(reading ? (cd ? "R7" : "R9") : "R12", "dout", dout, ed);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic bus_wr(input bit c, input logic [7:0] v);
      @(negedge clk);
      cs_n = 0; wr_n = 0; cd = c; din = v;
      @(negedge clk);
      cs_n = 1; wr_n = 1;
   endtask

   task automatic bus_rd(input bit c, output logic [7:0] v);
      @(negedge clk);
      cs_n = 0; rd_n = 0; cd = c;
      @(posedge clk); #8 v = dout;
      @(negedge clk);
      cs_n = 1; rd_n = 1;
   endtask

   task automatic rx_push(input logic [7:0] ch, input bit p, input bit f);
      @(negedge clk);
      rx_strobe = 1; rx_char = ch; rx_perr = p; rx_ferr = f;
      @(negedge clk);
      rx_strobe = 0; rx_perr = 0; rx_ferr = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1: reset state read through the status byte
      rst = 0;
      idle(1);
      bus_rd(1, v); check("R1", "status after reset", v, 8'h05);

      // R6: data write before the mode word is ignored
      bus_wr(0, 8'h77);
      bus_rd(1, v); check("R6", "txrdy after early data write", v[0], 1);

      // R2: write with chip select high does nothing
      @(negedge clk); cs_n = 1; wr_n = 0; cd = 1; din = 8'hFE;
      @(negedge clk); wr_n = 1;
      check("R2", "mode_ok with cs_n high", mode_ok, 0);

      // R3: first control write is the mode word
      bus_wr(1, 8'hFE);
      check("R3", "mode_o", mode_o, 8'hFE);
      // R4: commands
      bus_wr(1, 8'h22);
      check("R4", "dtr_n low", dtr_n, 0);
      check("R4", "rts_n low", rts_n, 0);
      check("R3", "mode unchanged by command", mode_o, 8'hFE);
      bus_wr(1, 8'h27);

      // R6: transmit holding register
      tx_busy = 1;
      bus_wr(0, 8'hA5);
      check("R6", "tx_avail", tx_avail, 1);
      check("R6", "tx_data", tx_data, 8'hA5);
      bus_rd(1, v); check("R7", "status with tx full", v & 8'h07, 8'h00);
      @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
      bus_rd(1, v); check("R7", "txrdy set, txempty clear while busy", v & 8'h05, 8'h01);
      tx_busy = 0;
      bus_rd(1, v); check("R7", "txempty", v[2], 1);

      // R8/R9: one character in and out
      rx_push(8'h3C, 0, 0);
      bus_rd(1, v); check("R8", "rxrdy", v[1], 1);
      bus_rd(0, v); check("R9", "read char", v, 8'h3C);
      bus_rd(1, v); check("R9", "rxrdy cleared", v[1], 0);

      // R10: overrun plus parity and framing
      rx_push(8'h11, 1, 0);
      rx_push(8'h22, 0, 1);
      bus_rd(1, v); check("R10", "error bits", v & 8'h38, 8'h38);
      bus_rd(0, v); check("R10", "latest char kept", v, 8'h22);
      bus_rd(1, v); check("R10", "errors sticky after read", v & 8'h38, 8'h38);

      // R11: error reset command
      bus_wr(1, 8'h37);
      bus_rd(1, v); check("R11", "errors cleared", v & 8'h38, 8'h00);

      // R8: receive disabled ignores characters
      bus_wr(1, 8'h23);
      rx_push(8'h99, 1, 1);
      bus_rd(1, v); check("R8", "no char while disabled", v & 8'h3A, 8'h00);

      // R7: break and data-set-ready inputs
      @(negedge clk); brk_det = 1; dsr_n = 0;
      bus_rd(1, v); check("R7", "brk and dsr bits", v & 8'hC0, 8'hC0);
      @(negedge clk); brk_det = 0; dsr_n = 1;

      // R2: a held read is one access; char arriving mid-hold stays ready
      bus_wr(1, 8'h27);
      rx_push(8'h5A, 0, 0);
      @(negedge clk); cs_n = 0; rd_n = 0; cd = 0;
      @(negedge clk); rx_strobe = 1; rx_char = 8'h6B;
      @(negedge clk); rx_strobe = 0;
      @(negedge clk); cs_n = 1; rd_n = 1;
      bus_rd(1, v); check("R2", "held read cleared once only", v[1], 1);
      check("R10", "no overrun on read-cycle char", v[4], 0);
      bus_rd(0, v);

      // R5: internal reset keeps outputs, next control write is a mode word
      bus_wr(1, 8'hFF);
      check("R5", "mode_ok cleared", mode_ok, 0);
      check("R5", "dtr_n kept", dtr_n, 0);
      check("R5", "brk_send not set", brk_send, 0);
      bus_wr(1, 8'h4E);
      check("R5", "new mode word", mode_o, 8'h4E);
      check("R5", "tx_en kept", tx_en, 1);
      bus_wr(1, 8'h80);
      check("R4", "hunt", hunt, 1);
      check("R4", "dtr_n high", dtr_n, 1);

      // R12 idle bus
      idle(2);
      check("R12", "dout idle", dout, 0);

      // R1: reset again mid-run
      @(negedge clk); rst = 1;
      idle(2);
      check("R1", "mode_ok in reset", mode_ok, 0);
      check("R1", "rts_n in reset", rts_n, 1);
      @(negedge clk); rst = 0;
      idle(2);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule